// File: doc/BRIEF.md
# Go-Back-N Retransmitting Sender

This block sits between a producer of data words and a link that can lose or corrupt them. It takes words from an upstream valid/ready stream and numbers each one with a 4-bit sequence number that wraps modulo 16. Every word is kept in an internal store until the far end acknowledges it. Words leave on a transmit stream that carries the word and its number.

The far end returns an acknowledgement message: a sequence number plus one polarity bit. A positive message for number k is cumulative and retires every word up to and including k. A negative message for number k retires the words before k. It also moves the transmit pointer back to k, so k and every later stored word are sent again in order.

A retry timer covers lost acknowledgements. If words have been sent and the oldest one stays unacknowledged for a programmable number of cycles, transmission rewinds to that oldest word. The window size is a parameter from 1 to 15. A window of 1 gives stop-and-wait operation.

Top module: `gbn_sender`

## Requirements
- R1: After reset, `in_ready_o` is 1 and `tx_valid_o` is 0.
- R2: Words are sent in the order they were accepted. The first word after reset carries number 0, and each following word carries the previous number plus 1. `tx_data_o` equals the accepted word.
- R3: While WIN accepted words are unacknowledged, `in_ready_o` is 0 and no word is taken.
- R4: A positive acknowledgement (`ack_nak_i`=0) for a sent, unacknowledged number k makes k+1 the oldest unacknowledged number. This frees the slots of the retired words for new intake.
- R5: An acknowledgement is ignored, of either polarity, when its number is not within the range of sent, unacknowledged words (from the oldest unacknowledged number up to the transmit pointer). Ignored means that neither the intake nor the transmit state changes.
- R6: A negative acknowledgement (`ack_nak_i`=1) for a sent, unacknowledged number k has two effects. It retires the words numbered below k. From the next cycle, transmission restarts at k and replays k and all later stored words in order.
- R7: With `timeout_i` nonzero, suppose sent words stay unacknowledged and the oldest unacknowledged number does not change for `timeout_i` cycles. Then transmission rewinds to that oldest word.
- R8: With `timeout_i` equal to 0, the retry timer never rewinds transmission.
- R9: Sequence numbers wrap from 15 to 0, and the window and acknowledgement range checks work across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Upstream word present |
| in_data_i | input | DATA_W | Upstream word |
| in_ready_o | output | 1 | Window has room for a new word |
| tx_valid_o | output | 1 | A stored word is waiting to be sent |
| tx_data_o | output | DATA_W | Word being offered to the link |
| tx_seq_o | output | 4 | Sequence number of the offered word |
| tx_ready_i | input | 1 | Link takes the offered word |
| ack_valid_i | input | 1 | Acknowledgement message present for one cycle |
| ack_nak_i | input | 1 | 0 = positive (cumulative), 1 = negative (resend request) |
| ack_seq_i | input | 4 | Number named by the acknowledgement |
| timeout_i | input | TMO_W | Retry limit in cycles; 0 disables the timer |

## Verification
The assertions assume that the upstream side holds `in_valid_i` and `in_data_i` steady only for the cycle it drives them. They assume that acknowledgement messages are single-cycle pulses. They also assume that `timeout_i` changes only rarely, because the timer bound is checked only when the limit is unchanged since the previous cycle. The stimulus drives all inputs on the falling edge. It changes `timeout_i` only while nothing is outstanding or while the link is stalled. It issues acknowledgements as isolated pulses, for in-range numbers it has tracked itself and for deliberately stale or future numbers.

// File: rtl/gbn_pkg.sv
package gbn_pkg;
  localparam int unsigned SEQ_W = 4;
  localparam int unsigned SEQ_N = 1 << SEQ_W;
  typedef logic [SEQ_W-1:0] seq_t;
  typedef enum logic {FB_POS = 1'b0, FB_NEG = 1'b1} fb_kind_e;
endpackage

// File: rtl/gbn_slot_store.sv
module gbn_slot_store
  import gbn_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  seq_t              wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  seq_t              rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] slot_q [SEQ_N];

  for (genvar g = 0; g < SEQ_N; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   slot_q[g] <= '0;
      else if (wr_en_i && (wr_idx_i == seq_t'(g)))   slot_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];
endmodule

// File: rtl/gbn_retry_timer.sv
module gbn_retry_timer #(
  parameter int unsigned TMO_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             armed_i,
  input  logic             restart_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);
  logic [TMO_W-1:0] cnt_q;

  assign expire_o = armed_i && (limit_i != '0) && (cnt_q >= limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (!armed_i || restart_i || expire_o) cnt_q <= '0;
    else if (cnt_q != '1)                     cnt_q <= cnt_q + 1'b1;
  end

  // limit unchanged since last cycle: count never passes it
  assert_timer_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_i != '0) && $stable(limit_i) |-> cnt_q <= limit_i - 1'b1);

  assert_timer_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_i == '0) |-> !expire_o);
endmodule

// File: rtl/gbn_window_ctrl.sv
module gbn_window_ctrl
  import gbn_pkg::*;
#(
  parameter int unsigned WIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  output logic in_ready_o,
  output logic push_o,
  output seq_t push_idx_o,
  input  logic tx_ready_i,
  output logic tx_valid_o,
  output seq_t tx_idx_o,
  input  logic ack_valid_i,
  input  logic ack_nak_i,
  input  seq_t ack_seq_i,
  input  logic expire_i,
  output logic armed_o,
  output logic base_move_o
);
  localparam seq_t WIN_S = seq_t'(WIN);

  seq_t base_q, next_q, snd_q;
  seq_t n_out, n_sent, ack_off;
  logic ack_ok, pos_ok, neg_ok, tmo_rew, tx_fire;

  assign n_out   = next_q - base_q;
  assign n_sent  = snd_q - base_q;
  assign ack_off = ack_seq_i - base_q;

  assign ack_ok  = ack_valid_i && (ack_off < n_sent);
  assign pos_ok  = ack_ok && (fb_kind_e'(ack_nak_i) == FB_POS);
  assign neg_ok  = ack_ok && (fb_kind_e'(ack_nak_i) == FB_NEG);
  assign tmo_rew = expire_i && !ack_ok;

  assign in_ready_o = n_out < WIN_S;
  assign push_o     = in_valid_i && in_ready_o;
  assign push_idx_o = next_q;

  assign tx_valid_o = snd_q != next_q;
  assign tx_idx_o   = snd_q;
  assign tx_fire    = tx_valid_o && tx_ready_i;

  assign armed_o     = n_sent != '0;
  assign base_move_o = ack_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      next_q <= '0;
      snd_q  <= '0;
    end else begin
      if (push_o) next_q <= next_q + 1'b1;
      if (pos_ok)      base_q <= ack_seq_i + 1'b1;
      else if (neg_ok) base_q <= ack_seq_i;
      if (neg_ok)       snd_q <= ack_seq_i;
      else if (tmo_rew) snd_q <= base_q;
      else if (tx_fire) snd_q <= snd_q + 1'b1;
    end
  end

  assert_window_limit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_out <= WIN_S);

  assert_sent_in_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_sent <= n_out);

  assert_tx_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_fire && !ack_ok && !expire_i |=> snd_q == $past(snd_q) + 1'b1);

  assert_pos_base_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_ok |=> base_q == $past(ack_seq_i) + 1'b1);

  assert_ignore_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_i && !ack_ok && !expire_i |=> $stable(base_q));

  assert_neg_rewind_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    neg_ok |=> (snd_q == $past(ack_seq_i)) && (base_q == $past(ack_seq_i)));

  assert_tmo_rewind_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i && !ack_valid_i |=> snd_q == base_q);
endmodule

// File: rtl/gbn_sender.sv
module gbn_sender
  import gbn_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WIN    = 4,
  parameter int unsigned TMO_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [3:0]        tx_seq_o,
  input  logic              tx_ready_i,
  input  logic              ack_valid_i,
  input  logic              ack_nak_i,
  input  logic [3:0]        ack_seq_i,
  input  logic [TMO_W-1:0]  timeout_i
);
  logic push, armed, expire, base_move;
  seq_t push_idx, tx_idx;

  gbn_window_ctrl #(.WIN(WIN)) u_ctrl (
    .clk_i, .rst_ni,
    .in_valid_i, .in_ready_o,
    .push_o(push), .push_idx_o(push_idx),
    .tx_ready_i, .tx_valid_o, .tx_idx_o(tx_idx),
    .ack_valid_i, .ack_nak_i, .ack_seq_i(seq_t'(ack_seq_i)),
    .expire_i(expire), .armed_o(armed), .base_move_o(base_move)
  );

  gbn_slot_store #(.DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(push), .wr_idx_i(push_idx), .wr_data_i(in_data_i),
    .rd_idx_i(tx_idx), .rd_data_o(tx_data_o)
  );

  gbn_retry_timer #(.TMO_W(TMO_W)) u_timer (
    .clk_i, .rst_ni,
    .armed_i(armed), .restart_i(base_move), .limit_i(timeout_i),
    .expire_o(expire)
  );

  assign tx_seq_o = tx_idx;

  assert_reset_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !tx_valid_o);
endmodule

// File: tb/gbn_sender_tb_top.sv
module gbn_sender_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 8;
  localparam int WIN = 4;
  localparam int TW  = 12;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, tx_valid, tx_ready = 0;
  logic [DW-1:0] in_data = '0, tx_data;
  logic [3:0] tx_seq, ack_seq = '0;
  logic ack_valid = 0, ack_nak = 0;
  logic [TW-1:0] timeout = '0;

  int checks = 0, errors = 0;
  logic [11:0] exp_q[$];
  logic [7:0]  mdl_data [16];
  logic [3:0]  mdl_next = 0;
  logic [3:0]  last_seq = 0;
  logic        last_ok = 0, wrapped = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gbn_sender #(.DATA_W(DW), .WIN(WIN), .TMO_W(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_seq_o(tx_seq), .tx_ready_i(tx_ready),
    .ack_valid_i(ack_valid), .ack_nak_i(ack_nak), .ack_seq_i(ack_seq),
    .timeout_i(timeout)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected items as words leave
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && tx_valid && tx_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R2 actual=%0h_%0h expected=none", tx_seq, tx_data);
        end else begin
          logic [11:0] e;
          e = exp_q.pop_front();
          if ({tx_seq, tx_data} !== e) begin
            errors++;
            $display("FAIL R2 actual=%0h_%0h expected=%0h_%0h", tx_seq, tx_data, e[11:8], e[7:0]);
          end
        end
        if (last_ok && last_seq == 4'hF && tx_seq == 4'h0) wrapped = 1;
        last_seq = tx_seq;
        last_ok  = 1;
      end
    end
  end

  task automatic push_word(input logic [7:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = d;
    mdl_data[mdl_next] = d;
    exp_q.push_back({mdl_next, d});
    mdl_next = mdl_next + 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic send_fb(input logic nak, input logic [3:0] k);
    @(negedge clk);
    ack_valid = 1; ack_nak = nak; ack_seq = k;
    @(negedge clk);
    ack_valid = 0;
  endtask

  task automatic drain();
    tx_ready = 1;
    for (int i = 0; i < 300 && (tx_valid || exp_q.size() != 0); i++) @(negedge clk);
    @(negedge clk);
    tx_ready = 0;
  endtask

  task automatic replay(input logic [3:0] from);
    exp_q.delete();
    for (logic [3:0] s = from; s != mdl_next; s++) exp_q.push_back({s, mdl_data[s]});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 ready", in_ready, 1);
    check("R1 idle", tx_valid, 0);

    for (int i = 0; i < WIN; i++) push_word(8'hA0 + 8'(i));
    check("R3 full", in_ready, 0);
    check("R2 head seq", tx_seq, 0);
    drain();
    check("R2 all sent", exp_q.size(), 0);

    repeat (40) @(negedge clk);
    check("R8 no timer resend", tx_valid, 0);

    send_fb(0, 4'd9);
    check("R5 stale ack", in_ready, 0);
    send_fb(1, 4'd7);
    check("R5 stray nak", tx_valid, 0);

    send_fb(0, 4'd1);                   // base 2
    check("R4 room", in_ready, 1);
    push_word(8'h51);
    push_word(8'h52);
    check("R3 full again", in_ready, 0);

    send_fb(1, 4'd3);                   // base 3, replay 3..5
    replay(4'd3);
    check("R6 rewind seq", tx_seq, 3);
    check("R6 rewind data", tx_data, mdl_data[3]);
    check("R6 below retired", in_ready, 1);
    drain();
    check("R6 replay done", exp_q.size(), 0);

    timeout = 12'd20;
    repeat (30) @(negedge clk);
    check("R7 timer rewind", tx_valid, 1);
    check("R7 timer seq", tx_seq, 3);
    timeout = '0;
    replay(4'd3);
    drain();
    check("R7 replay done", exp_q.size(), 0);

    send_fb(0, 4'd5);                   // base 6
    base = 4'd6;
    tx_ready = 1;
    last_ok = 0;
    fork
      for (int i = 0; i < 20; i++) push_word(8'hC0 + 8'(i));
      for (int j = 0; j < 60; j++) begin
        repeat (3) @(negedge clk);
        if (last_ok) begin
          ack_valid = 1; ack_nak = 0; ack_seq = last_seq;
          @(negedge clk);
          ack_valid = 0;
        end
      end
    join
    drain();
    check("R9 stream done", exp_q.size(), 0);
    check("R9 wrapped", wrapped, 1);
    send_fb(0, mdl_next - 1);
    check("R9 window free", in_ready, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule